// File: doc/BRIEF.md
# NEC Infrared Remote-Control Transmitter

This block turns a 32-bit remote-control code into a mark/space waveform on one output pin, following the NEC pulse-distance scheme. Software programs every phase length as a count of ticks from an external 1 MHz strobe, so one count is one microsecond. The lengths it sets are the leader mark and space, the short repeat-code space, the common data-bit mark, and separate spaces for a 0 bit and a 1 bit. It then loads the payload, takes ownership of the transmitter through a grant/lock arbitration register, and sets the enable bit. A mark drives the opposite of the programmed idle level, and a space drives the idle level.

A transmission is a first full frame followed by a programmable number of repeat frames. Frame starts are spaced by a programmable frame period. A repeat frame is either a full copy of the first frame or the short leader-plus-stop repeat code, as the format field selects. When the last frame's stop mark ends, a sticky end-of-transmission status bit is set. That bit drives the interrupt line when the interrupt is enabled, and software clears it by writing one. Clearing the enable bit at any time stops the waveform at once without raising the status.

Top module: `nec_ir_tx`

## Requirements
- R1: After reset the pin and the interrupt are low, and the control, arbitration, status and leader registers read zero.
- R2: A frame begins with a leader mark that lasts the leader-mark count in ticks (register 3 bits 15:0), then a leader space that lasts the leader-space count (register 3 bits 31:16). A mark drives the inverse of the idle-level bit (control bit 2), and a space drives the idle level.
- R3: After the leader, the 32 payload bits (register 7) go out least-significant bit first. Each bit is a mark of the bit-mark count (register 5 bits 15:0) followed by a space of the zero-space count (register 6 bits 15:0) or the one-space count (register 6 bits 31:16).
- R4: The last data bit is followed by a stop mark of the bit-mark count. The pin then holds the idle level, and while enable stays set no further frame is sent.
- R5: The repeat count (register 1 bits 15:0) sets how many repeat frames follow the first frame. In format 0 (control bits 7:4) each repeat frame is a leader mark, a repeat space of the count in register 4 bits 15:0, and a stop mark.
- R6: In format 1 every repeat frame is a full copy of the first frame.
- R7: Consecutive frame starts are spaced by the frame period (register 2 bits 17:0) in ticks, counted from the first mark of a frame. If a frame runs past that period, the next frame starts one tick after its stop mark.
- R8: The end status (register 9 bit 0) is set when the last stop mark ends and is cleared by writing 1 to it. The interrupt output equals that status gated by the interrupt enable (register 10 bit 0).
- R9: Writes to the two control registers (0 and 1) change only the bits of the lower half whose bit in the upper half of the written word is 1.
- R10: When the arbitration register (8) is clear, a write claims it only when it sets exactly one grant bit (bits 7:0) and the matching lock bit (bits 23:16). A claim of any other form is ignored, and so is a claim while another channel holds the register. Writing zero releases it. A frame starts only while this channel's grant and lock bits are both set.
- R11: Clearing enable (control bit 0) during a frame returns the pin to the idle level on the next cycle, and the end status is not set.
- R12: Any format other than 0 or 1 leaves the pin idle when enable is set.
- R13: A phase advances only on cycles where the tick strobe is high. Without ticks the pin holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 1 MHz time-base strobe, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| ir_o | output | 1 | Infrared output pin |
| irq_o | output | 1 | End-of-transmission interrupt |

## Verification
The hardest case to reach from the ports is the tick-gated phase timing in the middle of a live frame, together with an abort that lands among the data bits. Normal runs hold the tick high, which makes every phase last exactly its count in cycles and hides whether the counters really wait for the strobe. The bench therefore starts one frame with the tick held low and confirms that the leader mark persists. It then delivers single isolated ticks and confirms that the mark ends exactly on the ninth. It then runs into the data bits and clears the enable bit through a masked control write. Repeat trains use a short-repeat run with a long period and a full-repeat run whose period is shorter than a frame, so both gap rules of the spacing are exercised.

// File: rtl/nec_tx_pkg.sv
package nec_tx_pkg;

    localparam int DUR_W  = 16;
    localparam int PER_W  = 18;
    localparam int RPT_W  = 16;
    localparam int PAY_W  = 32;
    localparam int BIT_W  = $clog2(PAY_W);
    localparam int ADDR_W = 4;

    localparam logic [3:0] FMT_SHORT_RPT = 4'd0;
    localparam logic [3:0] FMT_FULL_RPT  = 4'd1;

    localparam logic [ADDR_W-1:0] A_CTRL   = 'd0;
    localparam logic [ADDR_W-1:0] A_RPT    = 'd1;
    localparam logic [ADDR_W-1:0] A_PERIOD = 'd2;
    localparam logic [ADDR_W-1:0] A_LEAD   = 'd3;
    localparam logic [ADDR_W-1:0] A_RSPACE = 'd4;
    localparam logic [ADDR_W-1:0] A_BMARK  = 'd5;
    localparam logic [ADDR_W-1:0] A_BSPACE = 'd6;
    localparam logic [ADDR_W-1:0] A_PAY    = 'd7;
    localparam logic [ADDR_W-1:0] A_ARB    = 'd8;
    localparam logic [ADDR_W-1:0] A_STS    = 'd9;
    localparam logic [ADDR_W-1:0] A_IEN    = 'd10;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LMARK,
        S_LSPACE,
        S_BMARK,
        S_BSPACE,
        S_RSPACE,
        S_STOP,
        S_GAP
    } tx_state_e;

    typedef struct packed {
        logic             en;
        logic             inact;
        logic [3:0]       fmt;
        logic [RPT_W-1:0] rpt;
        logic [PER_W-1:0] period;
        logic [DUR_W-1:0] lead_mark;
        logic [DUR_W-1:0] lead_space;
        logic [DUR_W-1:0] rpt_space;
        logic [DUR_W-1:0] bit_mark;
        logic [DUR_W-1:0] zero_space;
        logic [DUR_W-1:0] one_space;
        logic [PAY_W-1:0] payload;
    } tx_cfg_t;

endpackage

// File: rtl/nec_tx_arb.sv
module nec_tx_arb #(
    parameter int NUM_CH = 8,
    parameter int CH_ID  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [31:0]       wdata_i,
    output logic              owned_o,
    output logic [NUM_CH-1:0] grant_o,
    output logic [NUM_CH-1:0] lock_o,
    output logic [31:0]       rd_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] grant;
        logic [NUM_CH-1:0] lock;
    } arb_t;

    arb_t q, d;
    logic [NUM_CH-1:0] req_g, req_l;
    logic              is_free;

    always_comb begin
        d       = q;
        req_g   = wdata_i[NUM_CH-1:0];
        req_l   = wdata_i[16 +: NUM_CH];
        is_free = (q.grant == '0) && (q.lock == '0);
        if (wr_i) begin
            if (wdata_i == '0) begin
                d = '0;
            end else if (is_free && $onehot(req_g) && (req_g == req_l)) begin
                d.grant = req_g;
                d.lock  = req_l;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign owned_o = q.grant[CH_ID] & q.lock[CH_ID];
    assign grant_o = q.grant;
    assign lock_o  = q.lock;
    assign rd_o    = {16'(q.lock), 16'(q.grant)};

endmodule

// File: rtl/nec_tx_regs.sv
module nec_tx_regs
    import nec_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic              end_i,
    input  logic [31:0]       arb_rd_i,
    output tx_cfg_t           cfg_o,
    output logic              sts_o,
    output logic              irq_o,
    output logic [31:0]       rdata_o
);

    typedef struct packed {
        tx_cfg_t cfg;
        logic    sts;
        logic    ien;
    } regs_t;

    regs_t       q, d;
    logic [15:0] ctrl_now, ctrl_new;

    function automatic logic [15:0] masked(input logic [15:0] old, input logic [31:0] w);
        return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
    endfunction

    assign ctrl_now = {8'h00, q.cfg.fmt, 1'b0, q.cfg.inact, 1'b0, q.cfg.en};
    assign ctrl_new = masked(ctrl_now, wdata_i);

    always_comb begin
        d = q;
        if (wr_i) begin
            case (addr_i)
                A_CTRL: begin
                    d.cfg.en    = ctrl_new[0];
                    d.cfg.inact = ctrl_new[2];
                    d.cfg.fmt   = ctrl_new[7:4];
                end
                A_RPT:    d.cfg.rpt    = masked(q.cfg.rpt, wdata_i);
                A_PERIOD: d.cfg.period = wdata_i[PER_W-1:0];
                A_LEAD: begin
                    d.cfg.lead_mark  = wdata_i[DUR_W-1:0];
                    d.cfg.lead_space = wdata_i[16 +: DUR_W];
                end
                A_RSPACE: d.cfg.rpt_space = wdata_i[DUR_W-1:0];
                A_BMARK:  d.cfg.bit_mark  = wdata_i[DUR_W-1:0];
                A_BSPACE: begin
                    d.cfg.zero_space = wdata_i[DUR_W-1:0];
                    d.cfg.one_space  = wdata_i[16 +: DUR_W];
                end
                A_PAY:    d.cfg.payload = wdata_i[PAY_W-1:0];
                A_IEN:    d.ien = wdata_i[0];
                A_STS:    if (wdata_i[0]) d.sts = 1'b0;
                default: ;
            endcase
        end
        if (end_i) d.sts = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (addr_i)
            A_CTRL:   rdata_o = {16'h0000, ctrl_now};
            A_RPT:    rdata_o = 32'(q.cfg.rpt);
            A_PERIOD: rdata_o = 32'(q.cfg.period);
            A_LEAD:   rdata_o = {16'(q.cfg.lead_space), 16'(q.cfg.lead_mark)};
            A_RSPACE: rdata_o = 32'(q.cfg.rpt_space);
            A_BMARK:  rdata_o = 32'(q.cfg.bit_mark);
            A_BSPACE: rdata_o = {16'(q.cfg.one_space), 16'(q.cfg.zero_space)};
            A_PAY:    rdata_o = 32'(q.cfg.payload);
            A_ARB:    rdata_o = arb_rd_i;
            A_STS:    rdata_o = {31'd0, q.sts};
            A_IEN:    rdata_o = {31'd0, q.ien};
            default:  rdata_o = '0;
        endcase
    end

    assign cfg_o = q.cfg;
    assign sts_o = q.sts;
    assign irq_o = q.sts & q.ien;

endmodule

// File: rtl/nec_tx_frame.sv
module nec_tx_frame
    import nec_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  logic      owned_i,
    input  tx_cfg_t   cfg_i,
    output tx_state_e state_o,
    output logic      end_o,
    output logic      pin_o
);

    typedef struct packed {
        tx_state_e        st;
        logic [DUR_W-1:0] cnt;
        logic [BIT_W-1:0] bitn;
        logic [RPT_W-1:0] left;
        logic [PER_W-1:0] per;
        logic             rep;
        logic             done;
        logic             pin;
    } frm_t;

    frm_t             q, d;
    logic [DUR_W-1:0] dur;
    logic             run, step, end_c;

    always_comb begin
        d     = q;
        end_c = 1'b0;
        run   = cfg_i.en && owned_i &&
                (cfg_i.fmt == FMT_SHORT_RPT || cfg_i.fmt == FMT_FULL_RPT);

        case (q.st)
            S_LMARK:         dur = cfg_i.lead_mark;
            S_LSPACE:        dur = cfg_i.lead_space;
            S_BMARK, S_STOP: dur = cfg_i.bit_mark;
            S_BSPACE:        dur = cfg_i.payload[q.bitn] ? cfg_i.one_space : cfg_i.zero_space;
            S_RSPACE:        dur = cfg_i.rpt_space;
            default:         dur = '0;
        endcase
        step = tick_i && (({1'b0, q.cnt} + 1'b1) >= {1'b0, dur});

        if (tick_i) d.cnt = q.cnt + 1'b1;
        if (tick_i && q.st != S_IDLE && q.per != '1) d.per = q.per + 1'b1;

        if (!run) begin
            d.st   = S_IDLE;
            d.done = 1'b0;
        end else begin
            case (q.st)
                S_IDLE: if (!q.done) begin
                    d.st   = S_LMARK;
                    d.cnt  = '0;
                    d.per  = '0;
                    d.left = cfg_i.rpt;
                    d.rep  = 1'b0;
                end
                S_LMARK: if (step) begin
                    d.st  = (q.rep && cfg_i.fmt == FMT_SHORT_RPT) ? S_RSPACE : S_LSPACE;
                    d.cnt = '0;
                end
                S_LSPACE: if (step) begin
                    d.st   = S_BMARK;
                    d.bitn = '0;
                    d.cnt  = '0;
                end
                S_BMARK: if (step) begin
                    d.st  = S_BSPACE;
                    d.cnt = '0;
                end
                S_BSPACE: if (step) begin
                    d.cnt = '0;
                    if (q.bitn == BIT_W'(PAY_W - 1)) begin
                        d.st = S_STOP;
                    end else begin
                        d.st   = S_BMARK;
                        d.bitn = q.bitn + 1'b1;
                    end
                end
                S_RSPACE: if (step) begin
                    d.st  = S_STOP;
                    d.cnt = '0;
                end
                S_STOP: if (step) begin
                    if (q.left == '0) begin
                        d.st   = S_IDLE;
                        d.done = 1'b1;
                        end_c  = 1'b1;
                    end else begin
                        d.st = S_GAP;
                    end
                end
                S_GAP: if (tick_i && (({1'b0, q.per} + 1'b1) >= {1'b0, cfg_i.period})) begin
                    d.st   = S_LMARK;
                    d.cnt  = '0;
                    d.per  = '0;
                    d.left = q.left - 1'b1;
                    d.rep  = 1'b1;
                end
                default: d.st = S_IDLE;
            endcase
        end

        d.pin = (d.st == S_LMARK || d.st == S_BMARK || d.st == S_STOP) ?
                ~cfg_i.inact : cfg_i.inact;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign state_o = q.st;
    assign end_o   = end_c;
    assign pin_o   = q.pin;

endmodule

// File: rtl/nec_ir_tx.sv
module nec_ir_tx
    import nec_tx_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CH_ID  = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        wr_en_i,
    input  logic [3:0]  addr_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rdata_o,
    output logic        ir_o,
    output logic        irq_o
);

    tx_cfg_t           cfg;
    tx_state_e         state;
    logic              owned, end_pulse, sts;
    logic [NUM_CH-1:0] grant, lock;
    logic [31:0]       arb_rd;

    nec_tx_arb #(.NUM_CH(NUM_CH), .CH_ID(CH_ID)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_en_i && addr_i == A_ARB),
        .wdata_i (wdata_i),
        .owned_o (owned),
        .grant_o (grant),
        .lock_o  (lock),
        .rd_o    (arb_rd)
    );

    nec_tx_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_en_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .end_i    (end_pulse),
        .arb_rd_i (arb_rd),
        .cfg_o    (cfg),
        .sts_o    (sts),
        .irq_o    (irq_o),
        .rdata_o  (rdata_o)
    );

    nec_tx_frame u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .owned_i (owned),
        .cfg_i   (cfg),
        .state_o (state),
        .end_o   (end_pulse),
        .pin_o   (ir_o)
    );

endmodule

// File: rtl/nec_ir_tx_chk.sv
module nec_ir_tx_chk
    import nec_tx_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              wr_en_i,
    input logic              ir_o,
    input tx_state_e         state,
    input logic              owned,
    input logic              end_pulse,
    input logic              sts,
    input logic              cfg_en,
    input logic [3:0]        cfg_fmt,
    input logic [NUM_CH-1:0] grant,
    input logic [NUM_CH-1:0] lock
);

    // R13: no tick and no register write one cycle back -> pin holds
    assert_tick_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !$past(wr_en_i)) |=> $stable(ir_o));

    // R8: the end of the last stop mark sets the status
    assert_end_sets_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        end_pulse |=> sts);

    // R10: an idle channel without ownership stays idle
    assert_unowned_stays_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !owned) |=> (state == S_IDLE));

    // R10: at most one channel holds grant, with a matching lock
    assert_arb_single_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (grant == lock));

    // R11: cleared enable returns the sequencer to idle
    assert_disable_idles_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (state == S_IDLE));

    // R11: no end event while enable is clear
    assert_no_end_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> !end_pulse);

    // R12: formats other than 0 and 1 never leave idle
    assert_other_format_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fmt > 4'd1) |=> (state == S_IDLE));

endmodule

bind nec_ir_tx nec_ir_tx_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .ir_o      (ir_o),
    .state     (state),
    .owned     (owned),
    .end_pulse (end_pulse),
    .sts       (sts),
    .cfg_en    (cfg.en),
    .cfg_fmt   (cfg.fmt),
    .grant     (grant),
    .lock      (lock)
);

// File: tb/nec_ir_tx_test.sv
module nec_ir_tx_test;

    localparam int LM = 9, LS = 5, RS = 3, BM = 2, ZS = 1, OS = 3;
    localparam logic [3:0] R_CTRL = 0, R_RPT = 1, R_PER = 2, R_LEAD = 3, R_RSP = 4,
                           R_BMK = 5, R_BSP = 6, R_PAY = 7, R_ARB = 8, R_STS = 9, R_IEN = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ir, irq;

    int checks = 0;
    int fails  = 0;
    logic exp_q[$];

    always #2 clk = ~clk;

    nec_ir_tx uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ir_o(ir), .irq_o(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); addr = a; #1;
        chk(rdata == exp, req, $sformatf("read reg %0d", a), rdata, exp);
    endtask

    function automatic logic [31:0] c0(input bit en, input bit inact, input logic [3:0] fmt);
        return {16'h00FF, 8'h00, fmt, 1'b0, inact, 1'b0, en};
    endfunction

    function automatic int push_n(input logic lvl, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(lvl);
        return n;
    endfunction

    function automatic int push_full(input logic [31:0] data, input logic inact);
        int len;
        len = push_n(~inact, LM) + push_n(inact, LS);
        for (int i = 0; i < 32; i++) begin
            len += push_n(~inact, BM);
            len += push_n(inact, data[i] ? OS : ZS);
        end
        len += push_n(~inact, BM);
        return len;
    endfunction

    function automatic void build(input int fmt, input int rpts, input logic [31:0] data,
                                  input int per, input logic inact);
        int len;
        exp_q.delete();
        for (int f = 0; f <= rpts; f++) begin
            if (f == 0 || fmt == 1)
                len = push_full(data, inact);
            else
                len = push_n(~inact, LM) + push_n(inact, RS) + push_n(~inact, BM);
            if (f < rpts) void'(push_n(inact, (per - len > 1) ? per - len : 1));
        end
    endfunction

    task automatic run_expect(input string req);
        int k = 0;
        while (exp_q.size() > 0) begin
            logic e;
            e = exp_q.pop_front();
            @(negedge clk);
            chk(ir === e, req, $sformatf("pin at cycle %0d", k), ir, e);
            k++;
        end
        @(negedge clk);
    endtask

    task automatic idle_chk(input logic lvl, input int n, input string req);
        bit ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (ir !== lvl) ok = 1'b0;
        end
        chk(ok, req, "pin held idle", ~lvl, lvl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        chk(ir == 1'b0, "R1", "pin after reset", ir, 0);
        chk(irq == 1'b0, "R1", "irq after reset", irq, 0);
        rd_chk(R_CTRL, 0, "R1");
        rd_chk(R_ARB, 0, "R1");
        rd_chk(R_STS, 0, "R1");
        rd_chk(R_LEAD, 0, "R1");

        // R9 masked control writes
        wr(R_RPT, 32'h0000_1234); rd_chk(R_RPT, 32'h0, "R9");
        wr(R_RPT, 32'h00FF_1234); rd_chk(R_RPT, 32'h34, "R9");
        wr(R_RPT, 32'hFF00_AB00); rd_chk(R_RPT, 32'hAB34, "R9");
        wr(R_CTRL, 32'h0000_00F5); rd_chk(R_CTRL, 32'h0, "R9");
        wr(R_RPT, 32'hFFFF_0000);

        wr(R_LEAD, {16'(LS), 16'(LM)});
        wr(R_RSP, RS);
        wr(R_BMK, BM);
        wr(R_BSP, {16'(OS), 16'(ZS)});
        wr(R_PER, 200);
        wr(R_IEN, 1);
        tick = 1'b1;

        // R10 arbitration
        wr(R_ARB, 32'h0008_0008); rd_chk(R_ARB, 32'h0008_0008, "R10");
        wr(R_CTRL, c0(1, 0, 0));
        idle_chk(1'b0, 20, "R10");
        wr(R_ARB, 32'h0001_0001); rd_chk(R_ARB, 32'h0008_0008, "R10");
        wr(R_CTRL, c0(0, 0, 0));
        wr(R_ARB, 0); rd_chk(R_ARB, 0, "R10");
        wr(R_ARB, 32'h0002_0001); rd_chk(R_ARB, 0, "R10");
        wr(R_ARB, 32'h0001_0001); rd_chk(R_ARB, 32'h0001_0001, "R10");

        // R2 R3 R4 R8: single frame
        wr(R_PAY, 32'hA55A_3CC3);
        build(0, 0, 32'hA55A_3CC3, 200, 1'b0);
        wr(R_CTRL, c0(1, 0, 0));
        run_expect("R2,R3,R4");
        chk(ir == 1'b0, "R4", "pin after stop", ir, 0);
        chk(irq == 1'b1, "R8", "irq at end", irq, 1);
        rd_chk(R_STS, 1, "R8");
        idle_chk(1'b0, 20, "R4");
        wr(R_STS, 1); rd_chk(R_STS, 0, "R8");
        chk(irq == 1'b0, "R8", "irq after clear", irq, 0);

        // R5 R7: short repeats, long period, idle level high
        wr(R_CTRL, c0(0, 1, 0));
        wr(R_RPT, 32'hFFFF_0002);
        wr(R_PAY, 32'h0000_00FF);
        build(0, 2, 32'h0000_00FF, 200, 1'b1);
        wr(R_CTRL, c0(1, 1, 0));
        run_expect("R5,R7");
        chk(ir == 1'b1, "R5", "pin idle high after train", ir, 1);
        rd_chk(R_STS, 1, "R5");
        wr(R_STS, 1);

        // R6 R7 R8: full repeats, period shorter than a frame, irq masked
        wr(R_IEN, 0);
        wr(R_CTRL, c0(0, 0, 1));
        wr(R_RPT, 32'hFFFF_0001);
        wr(R_PER, 10);
        wr(R_PAY, 32'h1357_9BDF);
        build(1, 1, 32'h1357_9BDF, 10, 1'b0);
        wr(R_CTRL, c0(1, 0, 1));
        run_expect("R6,R7");
        chk(irq == 1'b0, "R8", "masked irq", irq, 0);
        rd_chk(R_STS, 1, "R8");
        wr(R_STS, 1);
        wr(R_IEN, 1);

        // R12 other formats
        wr(R_CTRL, c0(0, 0, 2));
        wr(R_CTRL, c0(1, 0, 2));
        idle_chk(1'b0, 40, "R12");
        wr(R_CTRL, c0(1, 0, 3));
        idle_chk(1'b0, 40, "R12");
        rd_chk(R_STS, 0, "R12");

        // R13 tick gating, then R11 abort
        wr(R_CTRL, c0(0, 1, 0));
        wr(R_RPT, 32'hFFFF_0000);
        @(negedge clk); tick = 1'b0;
        wr(R_CTRL, c0(1, 1, 0));
        @(negedge clk);
        chk(ir == 1'b0, "R13", "mark started", ir, 0);
        idle_chk(1'b0, 10, "R13");
        for (int t = 0; t < LM - 1; t++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
        chk(ir == 1'b0, "R13", "mark after 8 ticks", ir, 0);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        chk(ir == 1'b1, "R13", "space after 9th tick", ir, 1);
        @(negedge clk); tick = 1'b1;
        repeat (30) @(negedge clk);
        wr(R_CTRL, 32'h0001_0000);
        @(negedge clk);
        chk(ir == 1'b1, "R11", "pin idle after abort", ir, 1);
        idle_chk(1'b1, 300, "R11");
        rd_chk(R_STS, 0, "R11");
        chk(irq == 1'b0, "R11", "no irq after abort", irq, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule